// File: doc/BRIEF.md
# PRBS Receive Monitor with Interrupt

This block watches a received serial bit stream and decides whether it carries a 2^15-1 pseudo-random sequence built on the polynomial x^15 + x^14 + 1. The monitor needs no seed and no separate generator. It fills a 15-bit history register from the arriving bits, then predicts each later bit from that history and flags every mismatch. An invert control lets the monitor accept a complemented sequence.

Each received bit that fails its prediction increments a saturating 16-bit error counter. The bits are also grouped into back-to-back windows of 64 valid bits. At the end of each window a synchronization flag is updated: the stream is judged locked when the window held six errors or fewer. A change of that flag can set a sticky interrupt status. The edge-mode input decides whether only gaining lock sets it, or whether losing lock sets it too. The interrupt line is the sticky status gated by a mask. A single clear strobe empties both the sticky status and the error counter.

Top module: `prbs_rx_monitor`

## Requirements
- R1: After reset, sync_ok, irq_sticky and irq are 0 and err_cnt is 0.
- R2: The first 15 valid bits after reset only load the history and never count as errors. Each later valid bit, after the inversion of R3, is an error when it differs from the XOR of the bits received 14 and 15 valid bits earlier.
- R3: When inv_en is 1, each received bit is complemented before it is compared and stored. A complemented sequence then checks clean, and an uncomplemented one does not.
- R4: Valid bits form non-overlapping windows of 64, the first starting with the first valid bit after reset. At the 64th bit of a window, sync_ok becomes 1 if that window held 6 or fewer errors.
- R5: At the 64th bit of a window that held 7 or more errors, sync_ok becomes 0.
- R6: sync_ok changes only at the end of a window.
- R7: With any_edge at 0, only a 0-to-1 change of sync_ok sets irq_sticky. With any_edge at 1, a change in either direction sets it.
- R8: A clr pulse sets irq_sticky to 0, unless a qualifying change of sync_ok happens in the same cycle, in which case irq_sticky is 1.
- R9: irq is 1 exactly when irq_sticky is 1 and irq_mask is 1.
- R10: err_cnt increments by one per error bit and holds at 16'hFFFF.
- R11: clr sets err_cnt to 0, or to 1 if the bit in that same cycle is an error.
- R12: A cycle with bit_vld at 0 changes neither sync_ok nor err_cnt, whatever rx_bit does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | rx_bit carries a new bit this cycle |
| rx_bit | input | 1 | Received data bit |
| inv_en | input | 1 | Compare against the complemented sequence |
| any_edge | input | 1 | 0: only gaining lock is captured; 1: any lock change is captured |
| irq_mask | input | 1 | Enables irq |
| clr | input | 1 | Clears the sticky status and the error counter |
| sync_ok | output | 1 | Sequence lock status |
| irq_sticky | output | 1 | Sticky lock-change status |
| irq | output | 1 | Masked interrupt |
| err_cnt | output | 16 | Saturating bit error count |

## Verification
The hardest case to reach from the ports is the exact lock threshold. Because the history comes from the received bits, one corrupted bit also spoils the two predictions that later read it. A single flip therefore costs three errors, and two adjacent flips cost four. The bench places one flip and one more flip (six errors), or one flip and an adjacent pair (seven errors), early in an aligned window so that every echo stays inside it. Saturation is reached by complementing every transmitted bit for over 65,535 bits, which makes every prediction wrong.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_ANY  = 1'b1
  } irq_edge_e;

  typedef struct packed {
    logic done;
    logic cur;
    logic nxt;
  } win_evt_t;

endpackage

// File: rtl/prbs_ref_check.sv
module prbs_ref_check #(
  parameter int SEQ_LEN = 15,
  parameter int TAP_LO  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic rx_bit,
  input  logic inv_en,
  output logic bit_err
);
  localparam int FW = $clog2(SEQ_LEN + 1);

  logic [SEQ_LEN-1:0] hist_q;
  logic [FW-1:0]      fill_q;
  logic               filled, true_bit, pred_bit;

  function automatic logic predict(input logic [SEQ_LEN-1:0] h);
    return h[TAP_LO-1] ^ h[SEQ_LEN-1];
  endfunction

  assign filled   = (fill_q == FW'(SEQ_LEN));
  assign true_bit = rx_bit ^ inv_en;
  assign pred_bit = predict(hist_q);
  assign bit_err  = bit_vld && filled && (true_bit != pred_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_vld) begin
      hist_q <= {hist_q[SEQ_LEN-2:0], true_bit};
      if (!filled) fill_q <= fill_q + 1'b1;
    end
  end

  assert_fill_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> filled);
  assert_idle_no_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |-> !bit_err);

endmodule

// File: rtl/prbs_window.sv
module prbs_window import prbs_mon_pkg::*; #(
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bit_vld,
  input  logic     bit_err,
  output win_evt_t evt,
  output logic     sync_q
);
  localparam int PW = $clog2(WIN_LEN);
  localparam int EW = $clog2(WIN_LEN + 1);

  logic [PW-1:0] pos_q;
  logic [EW-1:0] errs_q, errs_tot;

  function automatic logic verdict(input logic [EW-1:0] e);
    return e <= EW'(ERR_LIMIT);
  endfunction

  assign errs_tot = errs_q + EW'(bit_err);
  assign evt.done = bit_vld && (pos_q == PW'(WIN_LEN - 1));
  assign evt.cur  = sync_q;
  assign evt.nxt  = verdict(errs_tot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      errs_q <= '0;
      sync_q <= 1'b0;
    end else if (bit_vld) begin
      if (evt.done) begin
        pos_q  <= '0;
        errs_q <= '0;
        sync_q <= evt.nxt;
      end else begin
        pos_q  <= pos_q + 1'b1;
        errs_q <= errs_tot;
      end
    end
  end

  assert_sync_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.done |=> $stable(sync_q));
  assert_errs_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    errs_q <= EW'(pos_q));

endmodule

// File: rtl/prbs_irq_ctrl.sv
module prbs_irq_ctrl import prbs_mon_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  win_evt_t  evt,
  input  irq_edge_e edge_sel,
  input  logic      irq_mask,
  input  logic      clr,
  output logic      sticky_q,
  output logic      irq
);
  logic sticky_set;

  function automatic logic qualifies(input logic cur, input logic nxt,
                                     input irq_edge_e m);
    return (cur != nxt) && ((m == EDGE_ANY) || nxt);
  endfunction

  assign sticky_set = evt.done && qualifies(evt.cur, evt.nxt, edge_sel);
  assign irq        = sticky_q & irq_mask;

  always_ff @(posedge clk) begin
    if (!rst_n)          sticky_q <= 1'b0;
    else if (sticky_set) sticky_q <= 1'b1;
    else if (clr)        sticky_q <= 1'b0;
  end

  assert_rise_after_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sticky_q) |-> $past(evt.done));
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !sticky_set) |=> !sticky_q);
  assert_mask_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq);

endmodule

// File: rtl/prbs_err_counter.sv
module prbs_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_err,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q
);
  function automatic logic [CNT_W-1:0] sat_next(input logic [CNT_W-1:0] cur,
                                                 input logic inc);
    if (inc && (cur != '1)) return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= CNT_W'(bit_err);
    else          cnt_q <= sat_next(cnt_q, bit_err);
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !clr) |=> cnt_q == '1);
  assert_step_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q != '1) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  assert_clear_small_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q <= CNT_W'(1));

endmodule

// File: rtl/prbs_rx_monitor.sv
module prbs_rx_monitor import prbs_mon_pkg::*; #(
  parameter int SEQ_LEN   = 15,
  parameter int TAP_LO    = 14,
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 6,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             rx_bit,
  input  logic             inv_en,
  input  logic             any_edge,
  input  logic             irq_mask,
  input  logic             clr,
  output logic             sync_ok,
  output logic             irq_sticky,
  output logic             irq,
  output logic [CNT_W-1:0] err_cnt
);
  logic     bit_err;
  win_evt_t win_evt;

  prbs_ref_check #(.SEQ_LEN(SEQ_LEN), .TAP_LO(TAP_LO)) u_ref (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .inv_en(inv_en), .bit_err(bit_err)
  );

  prbs_window #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_err(bit_err),
    .evt(win_evt), .sync_q(sync_ok)
  );

  prbs_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .evt(win_evt), .edge_sel(irq_edge_e'(any_edge)),
    .irq_mask(irq_mask), .clr(clr), .sticky_q(irq_sticky), .irq(irq)
  );

  prbs_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bit_err(bit_err), .clr(clr), .cnt_q(err_cnt)
  );

  assert_counter_moves_on_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !clr) |=> ($stable(err_cnt) && $stable(sync_ok)));

endmodule

// File: tb/test_prbs_rx_monitor.sv
`timescale 1ns/1ps
module test_prbs_rx_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0, rx_bit = 1'b0, inv_en = 1'b0, any_edge = 1'b0;
  logic irq_mask = 1'b1, clr = 1'b0;
  logic sync_ok, irq_sticky, irq;
  logic [15:0] err_cnt;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side sequence source and expected-state model
  logic [14:0] gen = 15'h0001;
  logic [14:0] mh = '0;
  int mfill = 0, mcnt = 0, mwp = 0, mwe = 0;
  logic msync = 0, msticky = 0;

  always #5 clk = ~clk;

  prbs_rx_monitor i_prbs_rx_monitor (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .inv_en(inv_en), .any_edge(any_edge), .irq_mask(irq_mask), .clr(clr),
    .sync_ok(sync_ok), .irq_sticky(irq_sticky), .irq(irq), .err_cnt(err_cnt)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic gen_next();
    logic n;
    n = gen[13] ^ gen[14];
    gen = {gen[13:0], n};
    return n;
  endfunction

  task automatic model(input logic vld, input logic b, input logic c);
    logic t, e, ns, setv;
    e = 1'b0; setv = 1'b0;
    if (vld) begin
      t = b ^ inv_en;
      if (mfill < 15) mfill++;
      else e = (t != (mh[13] ^ mh[14]));
      mh = {mh[13:0], t};
    end
    if (c) mcnt = int'(e);
    else if (e && mcnt < 65535) mcnt++;
    if (vld) begin
      mwe += int'(e);
      if (mwp == 63) begin
        ns = (mwe <= 6);
        setv = (ns != msync) && (any_edge || ns);
        msync = ns; mwp = 0; mwe = 0;
      end else mwp++;
    end
    if (setv) msticky = 1'b1;
    else if (c) msticky = 1'b0;
  endtask

  task automatic step(input logic vld, input logic b, input logic c);
    @(negedge clk);
    bit_vld = vld; rx_bit = b; clr = c;
    @(posedge clk);
    #1;
    model(vld, b, c);
    check("R4 sync_ok", int'(sync_ok), int'(msync));
    check("R7 irq_sticky", int'(irq_sticky), int'(msticky));
    check("R9 irq", int'(irq), int'(msticky & irq_mask));
    check("R10 err_cnt", int'(err_cnt), mcnt);
    bit_vld = 1'b0; clr = 1'b0;
  endtask

  // one aligned window; fa/fb/fc flip positions, clr_at clear position
  task automatic send_window(input int fa, input int fb, input int fc,
                             input int clr_at, input logic pol, input logic flip_all);
    for (int i = 0; i < 64; i++) begin
      logic b;
      b = gen_next() ^ pol ^ flip_all ^ ((i == fa) || (i == fb) || (i == fc));
      step(1'b1, b, i == clr_at);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    logic s0, k0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 sync_ok", int'(sync_ok), 0);
    check("R1 irq_sticky", int'(irq_sticky), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 err_cnt", int'(err_cnt), 0);
    rst_n = 1'b1;

    // first window: clean stream, lock gained
    send_window(-1, -1, -1, -1, 1'b0, 1'b0);
    check("R2 clean count", int'(err_cnt), 0);
    check("R4 lock gained", int'(sync_ok), 1);
    check("R7 rise captured", int'(irq_sticky), 1);
    check("R9 irq on", int'(irq), 1);
    irq_mask = 1'b0; #1;
    check("R9 irq masked", int'(irq), 0);
    irq_mask = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    check("R8 sticky cleared", int'(irq_sticky), 0);

    // six errors: single flips at 5 and 30 (three errors each)
    c0 = int'(err_cnt);
    send_window(5, 30, -1, -1, 1'b0, 1'b0);
    check("R2 six errors", int'(err_cnt) - c0, 6);
    check("R4 lock held at six", int'(sync_ok), 1);

    // seven errors: flip at 5 plus adjacent pair 30,31; rise-only mode
    c0 = int'(err_cnt);
    send_window(5, 30, 31, -1, 1'b0, 1'b0);
    check("R2 seven errors", int'(err_cnt) - c0, 7);
    check("R5 lock lost", int'(sync_ok), 0);
    check("R7 fall ignored", int'(irq_sticky), 0);

    // any-change mode
    any_edge = 1'b1;
    send_window(-1, -1, -1, -1, 1'b0, 1'b0);
    check("R7 rise any mode", int'(irq_sticky), 1);
    step(1'b0, 1'b0, 1'b1);
    send_window(5, 30, 31, -1, 1'b0, 1'b0);
    check("R5 lock lost again", int'(sync_ok), 0);
    check("R7 fall captured", int'(irq_sticky), 1);
    step(1'b0, 1'b0, 1'b1);
    check("R8 cleared before race", int'(irq_sticky), 0);

    // clear on the same bit as the window verdict: set wins
    send_window(-1, -1, -1, 63, 1'b0, 1'b0);
    check("R8 set beats clear", int'(irq_sticky), 1);
    check("R4 relocked", int'(sync_ok), 1);

    // clear on an errored bit: count restarts at one (+ echoes at 24,25)
    send_window(10, -1, -1, 10, 1'b0, 1'b0);
    check("R11 clear with error", int'(err_cnt), 3);

    // inversion
    inv_en = 1'b1;
    c0 = int'(err_cnt);
    send_window(-1, -1, -1, -1, 1'b1, 1'b0);
    send_window(-1, -1, -1, -1, 1'b1, 1'b0);
    check("R3 inverted clean", int'(err_cnt) - c0, 0);
    check("R3 inverted locked", int'(sync_ok), 1);
    send_window(-1, -1, -1, -1, 1'b0, 1'b0);
    send_window(-1, -1, -1, -1, 1'b0, 1'b0);
    check("R3 wrong polarity unlocked", int'(sync_ok), 0);
    inv_en = 1'b0;
    for (int w = 0; w < 3; w++) send_window(-1, -1, -1, -1, 1'b0, 1'b0);
    check("R3 relock plain", int'(sync_ok), 1);

    // idle cycles with toggling data
    c0 = int'(err_cnt); s0 = sync_ok; k0 = irq_sticky;
    for (int i = 0; i < 40; i++) step(1'b0, logic'(i % 3 == 0), 1'b0);
    check("R12 count idle", int'(err_cnt), c0);
    check("R12 sync idle", int'(sync_ok), int'(s0));
    check("R12 sticky idle", int'(irq_sticky), int'(k0));

    // saturation: every bit complemented
    for (int w = 0; w < 1030; w++) send_window(-1, -1, -1, -1, 1'b0, 1'b1);
    check("R10 saturated", int'(err_cnt), 65535);
    check("R5 unlocked under errors", int'(sync_ok), 0);
    step(1'b0, 1'b0, 1'b1);
    check("R11 cleared", int'(err_cnt), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule